// File: doc/BRIEF.md
# Sinc-Cubed Bitstream Decimator with PCM Formatter

This block turns the one-bit output of a sigma-delta modulator into two's-complement PCM words. Each accepted input bit is mapped to +1 or -1 and passed through three cascaded integrators. On every N-th accepted bit, three comb stages run at the decimated rate. Together they form a sinc-cubed low-pass decimator whose ratio N is chosen at reset from 32, 64, 128 or 256.

The full-precision filter result grows by log2(N) bits per stage. It is scaled down to 15 significant bits by an arithmetic right shift that depends on the selected ratio. The result is then packed into a 16-bit word. In plain data packing the 15 bits sit in the upper positions and the LSB is zero. In mixed packing the 15 bits sit in the lower positions and the MSB is a zero flag that marks the word as data. A result that reaches exact positive full scale is clamped to the largest positive code. In data packing that clamp is the only case in which the LSB is one.

Each word is announced by a one-cycle strobe. The first three decimation instants after reset produce no word, so that the comb delay lines hold real history before any output appears.

Top module: `cic3_pcm_decimator`

## Requirements
- R1: While `rstN` is low and after it is released, `outValid` is 0 and `outWord` is 0 until the first word is produced.
- R2: A clock edge with `inValid` low changes no filter state and produces no `outValid` in the following cycle. Each accepted bit maps as 1 → +1 and 0 → -1.
- R3: `outValid` is a single-cycle pulse in the cycle after the edge that accepts the N-th, 2N-th, ... bit since reset. The first three such instants are suppressed, so the first word follows the 4N-th accepted bit.
- R4: `osrSel` picks the ratio: 0 → 32, 1 → 64, 2 → 128, 3 → 256. It is sampled as static while the block is held in reset.
- R5: The filter result y for the word following accepted bit n is y = Σ h[k]·x[n−k], with x = ±1 per R2. The kernel h is the convolution of three all-ones boxcars of length N (3N−2 taps).
- R6: The 15-bit result is floor(y / 2^(3·log2(N) − 14)) in two's complement.
- R7: With `mixedMode` = 0, `outWord` = {result[14:0], 1'b0}.
- R8: When y equals N³, `outWord` is 16'h7FFF with `mixedMode` = 0, and 16'h3FFF with `mixedMode` = 1.
- R9: With `mixedMode` = 1, `outWord` = {1'b0, result[14:0]}. Bit 15 is the data flag and is always 0.
- R10: An all-zero window (y = −N³) gives result −16384: `outWord` 16'h8000 in data packing and 16'h4000 in mixed packing.
- R11: `mixedMode` is taken at the edge that accepts the bit completing a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Marks `inBit` as a modulator sample this cycle |
| inBit | input | 1 | Modulator bitstream bit |
| osrSel | input | 2 | Decimation ratio select (R4 encoding) |
| mixedMode | input | 1 | 0: data packing; 1: flag plus 15-bit packing |
| outValid | output | 1 | One-cycle strobe with each PCM word |
| outWord | output | 16 | Packed two's-complement PCM word |

## Verification
The bench drives long all-ones runs so that the window reaches exactly N³ at every ratio. A design without the clamp would wrap to a large negative code or emit an even LSB. It also drives all-zero runs to reach −N³, where a wrong shift or a too-narrow accumulator gives a wrong extreme code. Random gaps in `inValid` catch a design that counts idle cycles as samples, or that strobes off-beat or in the flush window one decimation period early or late. `mixedMode` changes from word to word to catch packing taken from the wrong cycle or a stray flag bit.

// File: rtl/cic3_pcm_pkg.sv
package cic3_pcm_pkg;
  // Ratio range as powers of two
  localparam int MIN_LOG2   = 5;
  localparam int MAX_LOG2   = 8;
  localparam int NUM_RATIOS = MAX_LOG2 - MIN_LOG2 + 1;
  localparam int SEL_BITS   = $clog2(NUM_RATIOS);
  // Filter order and word sizes
  localparam int ORDER      = 3;
  localparam int RES_BITS   = 15;
  localparam int OUT_BITS   = RES_BITS + 1;
  // Two bits beyond growth so +N^3 and -N^3 stay distinct
  localparam int ACC_BITS   = ORDER * MAX_LOG2 + 2;
  localparam int CNT_BITS   = MAX_LOG2;
  localparam int FLUSH_BITS = $clog2(ORDER + 1);

  typedef struct packed {
    logic                accept;  // integrators advance
    logic                tick;    // combs advance (every N-th accepted bit)
    logic                emit;    // tick past the flush window
    logic [SEL_BITS-1:0] ratio;   // selected ratio index
  } dec_ctrl_t;
endpackage

// File: rtl/cic3_ctrl.sv
module cic3_ctrl
  import cic3_pcm_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [SEL_BITS-1:0] osrSel,
  output dec_ctrl_t           ctrl
);
  logic [CNT_BITS-1:0]   sampleCnt;
  logic [CNT_BITS-1:0]   lastIdx;
  logic [FLUSH_BITS-1:0] flushCnt;
  logic                  tickNow;
  logic                  flushDone;

  localparam logic [FLUSH_BITS-1:0] FLUSH_TICKS = FLUSH_BITS'(ORDER);

  assign lastIdx   = CNT_BITS'((32'd1 << (MIN_LOG2 + int'(osrSel))) - 32'd1);
  assign tickNow   = inValid && (sampleCnt == lastIdx);
  assign flushDone = (flushCnt == FLUSH_TICKS);

  assign ctrl.accept = inValid;
  assign ctrl.tick   = tickNow;
  assign ctrl.emit   = tickNow && flushDone;
  assign ctrl.ratio  = osrSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleCnt <= '0;
      flushCnt  <= '0;
    end else if (inValid) begin
      sampleCnt <= tickNow ? '0 : sampleCnt + 1'b1;
      if (tickNow && !flushDone) flushCnt <= flushCnt + 1'b1;
    end
  end

  // R4: the phase counter never passes the selected ratio
  p_count_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    sampleCnt <= lastIdx);
  // R2: idle cycles leave the phase untouched
  p_gap_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(sampleCnt) && $stable(flushCnt));
  // R3: once flushed, stays flushed until reset
  p_flush_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    flushDone |=> flushDone);
endmodule

// File: rtl/cic3_formatter.sv
module cic3_formatter
  import cic3_pcm_pkg::*;
(
  input  logic signed [ACC_BITS-1:0] filtOut,
  input  logic [SEL_BITS-1:0]        ratio,
  input  logic                       mixedMode,
  output logic [OUT_BITS-1:0]        pcmWord
);
  logic [RES_BITS-1:0] resCand [NUM_RATIOS];
  logic                fsCand  [NUM_RATIOS];
  logic [RES_BITS-1:0] resSel;
  logic                fsSel;

  localparam logic [OUT_BITS-1:0] MAX_DATA  = {1'b0, {RES_BITS{1'b1}}};
  localparam logic [OUT_BITS-1:0] MAX_MIXED = {2'b00, {(RES_BITS-1){1'b1}}};

  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_ratio
    localparam int L  = MIN_LOG2 + g;
    localparam int SH = ORDER * L - (RES_BITS - 1);
    localparam logic [ACC_BITS-1:0] FS = {{(ACC_BITS-1){1'b0}}, 1'b1} << (ORDER * L);
    logic signed [ACC_BITS-1:0] shifted;
    assign shifted    = filtOut >>> SH;
    assign resCand[g] = shifted[RES_BITS-1:0];
    assign fsCand[g]  = (filtOut == FS);
  end

  assign resSel = resCand[ratio];
  assign fsSel  = fsCand[ratio];

  always_comb begin
    if (mixedMode) pcmWord = fsSel ? MAX_MIXED : {1'b0, resSel};
    else           pcmWord = fsSel ? MAX_DATA  : {resSel, 1'b0};
  end
endmodule

// File: rtl/cic3_datapath.sv
module cic3_datapath
  import cic3_pcm_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                inBit,
  input  logic                mixedMode,
  input  dec_ctrl_t           ctrl,
  output logic                outValid,
  output logic [OUT_BITS-1:0] outWord
);
  logic signed [ACC_BITS-1:0] xSample;
  logic signed [ACC_BITS-1:0] intg    [ORDER];
  logic signed [ACC_BITS-1:0] intgNext[ORDER];
  logic signed [ACC_BITS-1:0] combDly [ORDER];
  logic signed [ACC_BITS-1:0] combVal [ORDER+1];
  logic [OUT_BITS-1:0]        pcmWord;

  // R2: bit 1 -> +1, bit 0 -> -1
  assign xSample = inBit ? ACC_BITS'(1) : {ACC_BITS{1'b1}};

  for (genvar s = 0; s < ORDER; s++) begin : g_intg
    if (s == 0) begin : g_first
      assign intgNext[s] = intg[s] + xSample;
    end else begin : g_rest
      assign intgNext[s] = intg[s] + intgNext[s-1];
    end
    always_ff @(posedge clk) begin
      if (!rstN)           intg[s] <= '0;
      else if (ctrl.accept) intg[s] <= intgNext[s];
    end
  end

  assign combVal[0] = intgNext[ORDER-1];

  for (genvar s = 0; s < ORDER; s++) begin : g_comb
    assign combVal[s+1] = combVal[s] - combDly[s];
    always_ff @(posedge clk) begin
      if (!rstN)         combDly[s] <= '0;
      else if (ctrl.tick) combDly[s] <= combVal[s];
    end
  end

  cic3_formatter u_fmt (
    .filtOut   (combVal[ORDER]),
    .ratio     (ctrl.ratio),
    .mixedMode (mixedMode),
    .pcmWord   (pcmWord)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outWord  <= '0;
    end else begin
      outValid <= ctrl.emit;
      if (ctrl.emit) outWord <= pcmWord;
    end
  end

  // R3: strobe lasts one cycle
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);
  // R3: strobe only follows an emitting decimation instant
  p_valid_from_emit_r3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(ctrl.emit));
  // R7, R8: data packing has an odd LSB only for the clamp code
  p_data_lsb_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !$past(mixedMode)) |-> (!outWord[0] || outWord == {1'b0, {RES_BITS{1'b1}}}));
  // R9: mixed packing always flags data
  p_mixed_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(mixedMode)) |-> !outWord[OUT_BITS-1]);
endmodule

// File: rtl/cic3_pcm_decimator.sv
module cic3_pcm_decimator
  import cic3_pcm_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic                inBit,
  input  logic [SEL_BITS-1:0] osrSel,
  input  logic                mixedMode,
  output logic                outValid,
  output logic [OUT_BITS-1:0] outWord
);
  dec_ctrl_t ctrl;

  cic3_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .osrSel  (osrSel),
    .ctrl    (ctrl)
  );

  cic3_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .inBit     (inBit),
    .mixedMode (mixedMode),
    .ctrl      (ctrl),
    .outValid  (outValid),
    .outWord   (outWord)
  );
endmodule

// File: tb/cic3_pcm_decimator_bench.sv
module cic3_pcm_decimator_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, inValid, inBit, mixedMode, outValid;
  logic [1:0]  osrSel;
  logic [15:0] outWord;

  cic3_pcm_decimator u_cic3_pcm_decimator (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inBit(inBit),
    .osrSel(osrSel), .mixedMode(mixedMode), .outValid(outValid), .outWord(outWord)
  );

  int  checks = 0, errors = 0;
  bit  done = 1'b0;
  bit  histBit [8192];
  bit  histMode[8192];
  int  hTab[800];
  int  cnt, nRatio, lg, wordsSeen, fsSeen, negSeen;
  bit  prevAcc;

  task automatic buildTaps(input int n);
    for (int k = 0; k <= 3*n-3; k++) begin
      int c = 0;
      for (int a = 0; a < n; a++) begin
        int r = k - a;
        if (r >= 0 && r <= 2*n-2) begin
          int lo = (r - (n-1)) < 0 ? 0 : r - (n-1);
          int hi = r < (n-1) ? r : n-1;
          c += hi - lo + 1;
        end
      end
      hTab[k] = c;
    end
  endtask

  function automatic longint filt(input int last);
    longint acc = 0;
    for (int k = 0; k <= 3*nRatio-3; k++)
      acc += longint'(hTab[k]) * (histBit[last-k] ? 1 : -1);
    return acc;
  endfunction

  function automatic logic [15:0] expWord(input longint y, input bit m);
    longint fsv = longint'(1) << (3*lg);
    logic [14:0] r = 15'(y >>> (3*lg - 14));
    if (y == fsv) return m ? 16'h3FFF : 16'h7FFF;
    return m ? {1'b0, r} : {r, 1'b0};
  endfunction

  task automatic checkOut();
    bit expV = prevAcc && (cnt % nRatio == 0) && (cnt / nRatio >= 4);
    if (expV || outValid) begin
      checks++;
      if (outValid !== expV) begin
        errors++;
        if (!prevAcc) $display("FAIL R2 strobe after idle cycle: got %0b exp 0", outValid);
        else $display("FAIL R3 strobe at sample %0d: got %0b exp %0b", cnt, outValid, expV);
      end else begin
        longint y = filt(cnt-1);
        bit m = histMode[cnt-1];
        logic [15:0] e = expWord(y, m);
        wordsSeen++;
        if (y == (longint'(1) << (3*lg))) fsSeen++;
        if (y == -(longint'(1) << (3*lg))) negSeen++;
        checks++;
        if (outWord !== e) begin
          errors++;
          if (y == (longint'(1) << (3*lg))) $display("FAIL R8 clamp: got %h exp %h", outWord, e);
          else if (y == -(longint'(1) << (3*lg))) $display("FAIL R10 low extreme: got %h exp %h", outWord, e);
          else if (m) $display("FAIL R9 R11 mixed word y=%0d: got %h exp %h", y, outWord, e);
          else $display("FAIL R5 R6 R7 data word y=%0d: got %h exp %h", y, outWord, e);
        end
      end
    end
  endtask

  task automatic step(input bit v, input bit b, input bit m);
    @(negedge clk);
    checkOut();
    inValid = v; inBit = b; mixedMode = m;
    if (v) begin histBit[cnt] = b; histMode[cnt] = m; cnt++; end
    prevAcc = v;
  endtask

  task automatic runSeg(input int samples, input int pct);
    int got = 0;
    while (got < samples) begin
      bit v = ($urandom % 4) != 0;
      bit b = ($urandom % 100) < pct;
      bit m = (((cnt / nRatio) * 7 + lg) % 3) == 0;
      step(v, b, m);
      if (v) got++;
    end
  endtask

  task automatic runRatio(input int g);
    lg = 5 + g; nRatio = 1 << lg;
    buildTaps(nRatio);
    rstN = 1'b0; inValid = 1'b0; inBit = 1'b0; mixedMode = 1'b0; osrSel = 2'(g);
    repeat (3) @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || outWord !== 16'h0) begin
      errors++;
      $display("FAIL R1 reset state: got %0b/%h exp 0/0000", outValid, outWord);
    end
    cnt = 0; prevAcc = 1'b0; wordsSeen = 0; fsSeen = 0; negSeen = 0;
    rstN = 1'b1;
    runSeg(5*nRatio, 50);
    runSeg(4*nRatio, 100);
    runSeg(4*nRatio, 0);
    runSeg(4*nRatio, 85);
    runSeg(4*nRatio, 15);
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    checks++;
    if (wordsSeen != cnt / nRatio - 3) begin
      errors++;
      $display("FAIL R4 word count ratio %0d: got %0d exp %0d", nRatio, wordsSeen, cnt / nRatio - 3);
    end
    checks++;
    if (fsSeen == 0) begin errors++; $display("FAIL R8 no clamp seen ratio %0d: got 0 exp >0", nRatio); end
    checks++;
    if (negSeen == 0) begin errors++; $display("FAIL R10 no low extreme ratio %0d: got 0 exp >0", nRatio); end
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int g = 0; g < 4; g++) runRatio(g);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: got running exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule